// File: doc/BRIEF.md
# KISS Frame Byte Encoder

This block takes frames arriving as a byte stream (valid/ready handshake plus an end-of-frame marker) and turns them into a delimited, transparent byte stream for a serial transmitter. Every frame is wrapped between two delimiter bytes. Any payload byte that equals the delimiter or the escape code is replaced by a two-byte escape sequence. The result can go straight to a UART transmitter with valid/ready flow control.

The first payload byte gets no special handling. Any command or port byte is supplied by the producer as ordinary data. A side input marks a beat as carrying no byte. This allows a frame with no payload to be closed by a lone end marker.

Internally, one output register is backed by a small queue of up to three bytes. The queue holds the remainder of the sequence generated by a single input beat. While that queue holds anything, the input side is held off. This way, escapes and delimiters leave one per output handshake, and no input byte is lost or reordered.

Top module: `kiss_frame_encoder`

## Requirements
- R1: The delimiter is 0xC0. The first accepted data byte of each frame is preceded on the output by one 0xC0.
- R2: A data byte equal to 0xC0 leaves as the pair 0xDB, 0xDC, in that order.
- R3: A data byte equal to 0xDB leaves as the pair 0xDB, 0xDD, in that order.
- R4: After the byte accepted with `in_last` high, a closing 0xC0 is sent. The next frame starts with a fresh opening 0xC0 after it.
- R5: All other byte values, including the first byte of a frame, pass through unchanged and in order.
- R6: `in_ready` is low while any byte produced by an earlier input beat is still waiting behind the output register.
- R7: A beat with `in_nul` and `in_last` both high, in a frame with no data yet, yields exactly 0xC0, 0xC0.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: A beat with `in_nul` high and `in_last` low produces no output byte and does not open a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Input beat is valid |
| in_last | input | 1 | Beat ends the frame |
| in_nul | input | 1 | Beat carries no payload byte |
| in_ready | output | 1 | Encoder accepts the beat this cycle |
| out_data | output | 8 | Encoded byte |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | Transmitter takes the byte this cycle |

## Verification
The assertions assume that the producer holds its beat steady until it is taken. They also assume that `in_nul` is meaningful only alongside `in_valid`. The stimulus changes inputs only after a handshake has been observed. The assertions further assume that the transmitter may stall for any number of cycles. For that reason, the stimulus runs each stream under continuous, sparse and periodic ready patterns. This exposes every byte of every escape and delimiter sequence to back-pressure.

// File: rtl/kiss_enc_pkg.sv
package kiss_enc_pkg;
    localparam int BYTE_W     = 8;
    localparam int PEND_DEPTH = 3;
    localparam int SEQ_MAX    = PEND_DEPTH + 1;
    localparam int CNT_W      = $clog2(SEQ_MAX + 1);

    localparam logic [BYTE_W-1:0] CODE_DELIM   = 8'hC0;
    localparam logic [BYTE_W-1:0] CODE_ESC     = 8'hDB;
    localparam logic [BYTE_W-1:0] CODE_T_DELIM = 8'hDC;
    localparam logic [BYTE_W-1:0] CODE_T_ESC   = 8'hDD;

    typedef logic [SEQ_MAX-1:0][BYTE_W-1:0]    seq_t;
    typedef logic [PEND_DEPTH-1:0][BYTE_W-1:0] pend_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ob;
        logic              ov;
        pend_t             pb;
        logic [CNT_W-1:0]  pcnt;
        logic              open;
    } enc_state_t;
endpackage

// File: rtl/kiss_esc_map.sv
module kiss_esc_map
    import kiss_enc_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic              esc_o,
    output logic [BYTE_W-1:0] code_o
);
    always_comb begin
        esc_o  = 1'b0;
        code_o = byte_i;
        if (byte_i == CODE_DELIM) begin
            esc_o  = 1'b1;
            code_o = CODE_T_DELIM;
        end else if (byte_i == CODE_ESC) begin
            esc_o  = 1'b1;
            code_o = CODE_T_ESC;
        end
    end
endmodule

// File: rtl/kiss_seq_build.sv
module kiss_seq_build
    import kiss_enc_pkg::*;
(
    input  logic [BYTE_W-1:0] data_i,
    input  logic              last_i,
    input  logic              nul_i,
    input  logic              open_i,
    output seq_t              seq_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              open_o
);
    logic              esc;
    logic [BYTE_W-1:0] code;

    kiss_esc_map u_map (
        .byte_i (data_i),
        .esc_o  (esc),
        .code_o (code)
    );

    always_comb begin
        logic [CNT_W-1:0] k;
        seq_o = '0;
        k     = '0;
        if (!open_i && (!nul_i || last_i)) begin
            seq_o[k] = CODE_DELIM;
            k        = k + 1'b1;
        end
        if (!nul_i) begin
            if (esc) begin
                seq_o[k] = CODE_ESC;
                k        = k + 1'b1;
                seq_o[k] = code;
                k        = k + 1'b1;
            end else begin
                seq_o[k] = data_i;
                k        = k + 1'b1;
            end
        end
        if (last_i) begin
            seq_o[k] = CODE_DELIM;
            k        = k + 1'b1;
        end
        cnt_o  = k;
        open_o = last_i ? 1'b0 : (nul_i ? open_i : 1'b1);
    end
endmodule

// File: rtl/kiss_enc_core.sv
module kiss_enc_core
    import kiss_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_nul,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    enc_state_t       s_q, s_d;
    seq_t             seq;
    logic [CNT_W-1:0] seq_cnt;
    logic             open_nx;
    logic             slot_free;
    logic             in_fire;

    kiss_seq_build u_seq (
        .data_i (in_data),
        .last_i (in_last),
        .nul_i  (in_nul),
        .open_i (s_q.open),
        .seq_o  (seq),
        .cnt_o  (seq_cnt),
        .open_o (open_nx)
    );

    assign slot_free = !s_q.ov || out_ready;
    assign in_ready  = (s_q.pcnt == '0) && slot_free;
    assign in_fire   = in_valid && in_ready;
    assign out_data  = s_q.ob;
    assign out_valid = s_q.ov;

    always_comb begin
        s_d = s_q;
        if (slot_free) begin
            if (s_q.pcnt != '0) begin
                s_d.ob   = s_q.pb[0];
                s_d.pb   = {{BYTE_W{1'b0}}, s_q.pb[PEND_DEPTH-1:1]};
                s_d.pcnt = s_q.pcnt - 1'b1;
                s_d.ov   = 1'b1;
            end else if (in_fire && seq_cnt != '0) begin
                s_d.ob   = seq[0];
                s_d.pb   = seq[SEQ_MAX-1:1];
                s_d.pcnt = seq_cnt - 1'b1;
                s_d.ov   = 1'b1;
            end else begin
                s_d.ov   = 1'b0;
            end
        end
        if (in_fire) begin
            s_d.open = open_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    p_open_delim_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && !in_nul && !s_q.open |=> out_valid && out_data == CODE_DELIM);

    p_esc_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_data == CODE_ESC
        |=> out_valid && (out_data == CODE_T_DELIM || out_data == CODE_T_ESC));

    p_esc_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && !in_nul && s_q.open && in_data == CODE_ESC
        |=> out_valid && out_data == CODE_ESC);

    p_hold_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_data == CODE_ESC |-> !in_ready);

    p_empty_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && in_nul && in_last && !s_q.open
        |=> out_valid && out_data == CODE_DELIM && s_q.pcnt == 1);

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/kiss_frame_encoder.sv
module kiss_frame_encoder
    import kiss_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              in_nul,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    kiss_enc_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_nul    (in_nul),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );
endmodule

// File: tb/kiss_frame_encoder_test.sv
module kiss_frame_encoder_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_nul = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [7:0] sd [0:63];
    bit         sl [0:63];
    bit         sn [0:63];
    int         ns = 0;
    logic [7:0] ex [0:255];
    int         ne = 0;
    logic [7:0] got [0:255];
    int         ng = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kiss_frame_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_nul(in_nul), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_nul = 1'b0; in_last = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic add(input logic [7:0] d, input bit l, input bit n);
        sd[ns] = d; sl[ns] = l; sn[ns] = n; ns++;
    endtask

    task automatic put(input logic [7:0] b);
        ex[ne] = b; ne++;
    endtask

    task automatic build_expect();
        bit open = 0;
        ne = 0;
        for (int i = 0; i < ns; i++) begin
            if (sn[i]) begin
                if (sl[i]) begin
                    if (!open) put(8'hC0);
                    put(8'hC0);
                    open = 0;
                end
            end else begin
                if (!open) put(8'hC0);
                open = 1;
                if (sd[i] == 8'hC0) begin put(8'hDB); put(8'hDC); end
                else if (sd[i] == 8'hDB) begin put(8'hDB); put(8'hDD); end
                else put(sd[i]);
                if (sl[i]) begin put(8'hC0); open = 0; end
            end
        end
    endtask

    // Drives the stream under a ready pattern and compares against the model.
    task automatic run(input int mode, input string tag);
        int  idx = 0;
        int  cyc = 0;
        bit  inf, outf;
        build_expect();
        ng = 0;
        while ((idx < ns || ng < ne || out_valid) && cyc < 3000) begin
            @(negedge clk);
            case (mode)
                0: out_ready = 1'b1;
                1: out_ready = (cyc % 3) != 0;
                default: out_ready = (cyc % 4) == 0;
            endcase
            in_valid = idx < ns;
            if (idx < ns) begin
                in_data = sd[idx]; in_last = sl[idx]; in_nul = sn[idx];
            end
            #1;
            inf  = in_valid && in_ready;
            outf = out_valid && out_ready;
            @(posedge clk);
            if (inf) idx++;
            if (outf && ng < 256) begin got[ng] = out_data; ng++; end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0;
        chk(cyc < 3000, {tag, " watchdog"}, cyc, 3000);
        chk(ng == ne, {tag, " count"}, ng, ne);
        for (int i = 0; i < ne && i < ng; i++)
            chk(got[i] == ex[i], tag, got[i], ex[i]);
        ns = 0;
    endtask

    task automatic t_reset_r9();
        do_reset();
        #1;
        chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    endtask

    task automatic t_plain_r5_r1();
        add(8'h00, 0, 0); add(8'hFF, 0, 0); add(8'hC1, 0, 0); add(8'hDA, 1, 0);
        run(0, "R5/R1 plain");
        add(8'h7E, 0, 0); add(8'hDE, 1, 0);
        run(2, "R5 plain sparse");
    endtask

    task automatic t_escapes_r2_r3();
        add(8'hC0, 0, 0); add(8'h41, 0, 0); add(8'hDB, 0, 0); add(8'hDC, 0, 0);
        add(8'hDD, 0, 0); add(8'hC0, 1, 0);
        run(1, "R2/R3 escapes");
        add(8'hDB, 1, 0);
        run(2, "R3 lone esc");
    endtask

    task automatic t_back_to_back_r4();
        add(8'h11, 1, 0); add(8'h22, 0, 0); add(8'h33, 1, 0); add(8'hC0, 1, 0);
        run(0, "R4 frames");
    endtask

    task automatic t_empty_r7_r10();
        add(8'h00, 1, 1);
        run(1, "R7 empty");
        add(8'h55, 0, 1); add(8'h66, 1, 0);
        run(0, "R10 nul");
        add(8'h12, 0, 0); add(8'h00, 1, 1);
        run(2, "R7 nul close");
    endtask

    task automatic t_stall_r6_r8();
        do_reset();
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_data = 8'hC0; in_last = 1'b1; in_nul = 1'b0;
        @(negedge clk);
        in_data = 8'h44;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R6 ready low", in_ready, 0);
            chk(out_valid == 1'b1 && out_data == 8'hC0, "R8 hold", out_data, 8'hC0);
        end
        in_valid = 1'b0;
        do_reset();
    endtask

    initial begin
        t_reset_r9();
        t_plain_r5_r1();
        t_escapes_r2_r3();
        t_back_to_back_r4();
        t_empty_r7_r10();
        t_stall_r6_r8();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule